// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Commit

This block is the in-order retirement stage of a small out-of-order core. At dispatch it hands each instruction, in program order, a slot in a circular buffer and returns that slot number as the tag the instruction carries through execution. Results come back out of order on a result broadcast bus, keyed by tag. The matching slot records the value and marks itself complete.

Retirement is strictly in order from the oldest slot, at most one slot per cycle, and only once that slot's result has arrived. A retiring ALU or load instruction drives the register-file write port. A retiring store drives the memory write port, and this is the only time a store reaches memory. A retiring branch that resolved as mispredicted raises a one-cycle redirect carrying the correct target and discards every younger slot, so the buffer is empty on the next cycle. The buffer has 16 slots with 4-bit tags. Each pointer carries one extra wrap bit so that a full buffer can be told apart from an empty one.

Top module: `rob_commit_top`

## Requirements
- R1: After reset the buffer is empty: `dispReady` is 1, `dispTag` is 0, and `commitValid`, `regWrEn`, `memWrEn` and `redirectValid` are all 0.
- R2: Each accepted dispatch (`dispValid` and `dispReady` both high at a clock edge) receives the tag shown on `dispTag` in that cycle. Later dispatches receive consecutive tags modulo 16.
- R3: While 16 slots are occupied, `dispReady` is 0. A dispatch offered then is not accepted and leaves `dispTag` unchanged.
- R4: A result (`resValid`, `resTag`, `resValue`, `resMispredict`) is stored in the valid slot with that tag. Slots may complete in any order, but nothing retires while the oldest slot has no result.
- R5: Slots retire in allocation order, at most one per cycle, with `commitTag` naming the slot. An ALU (kind 0) or load (kind 1) slot retires with `regWrEn`=1, `regWrAddr` equal to its destination, `regWrData` equal to its result, and `memWrEn`=0.
- R6: A store (kind 2) slot retires with `memWrEn`=1, `memWrAddr` equal to the address given at dispatch, `memWrData` equal to its result, and `regWrEn`=0. Memory is never written outside retirement.
- R7: A branch (kind 3) whose result arrived with `resMispredict`=0 retires with no register write, no memory write and no redirect.
- R8: A branch whose result arrived with `resMispredict`=1 retires with a one-cycle `redirectValid` and with `redirectPc` equal to its result value. All younger slots are cancelled: none of them retires, the buffer is empty on the next cycle, the next tag allocated is the branch tag plus 1, and later results sent to cancelled tags have no effect.
- R9: A result sent to a tag that holds no valid slot is ignored. A slot allocated later under that tag still waits for its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | An instruction is offered for allocation |
| dispKind | input | 2 | Instruction kind: 0 ALU, 1 load, 2 store, 3 branch |
| dispDest | input | 5 | Destination register |
| dispAddr | input | 32 | Store address (ignored for other kinds) |
| dispReady | output | 1 | A slot is free and a dispatch will be accepted |
| dispTag | output | 4 | Tag given to the instruction offered this cycle |
| resValid | input | 1 | Result bus carries a result |
| resTag | input | 4 | Tag of the completing slot |
| resValue | input | 32 | Result value, store data, or branch target |
| resMispredict | input | 1 | Branch resolved as mispredicted |
| commitValid | output | 1 | The oldest slot retires this cycle |
| commitTag | output | 4 | Tag of the retiring slot |
| regWrEn | output | 1 | Register-file write strobe |
| regWrAddr | output | 5 | Register-file write address |
| regWrData | output | 32 | Register-file write data |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 32 | Memory write address |
| memWrData | output | 32 | Memory write data |
| redirectValid | output | 1 | One-cycle fetch redirect on a mispredicted branch |
| redirectPc | output | 32 | Correct branch target |

## Verification
Allocation at the tail and retirement at the head can fall in the same cycle. The bench provokes this by streaming dispatches, sending each one together with the result of the instruction dispatched just before it, so that a slot retires on every cycle in which a new slot is claimed. The check is that every retirement matches, in tag order and content, the scoreboard entry recorded at dispatch, and that the dispatch tags stay consecutive throughout. A mispredicted branch is also retired while younger slots already hold results; the bench expects none of those younger slots to appear at the write ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KindAlu    = 2'd0,
    KindLoad   = 2'd1,
    KindStore  = 2'd2,
    KindBranch = 2'd3
  } instKind_e;

  // Strobes from the pointer control to the entry storage
  typedef struct packed {
    logic allocEn;
    logic commitEn;
    logic flushAll;
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int TagW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dispValid,
  input  logic            headValid,
  input  logic            headDone,
  input  instKind_e       headKind,
  input  logic            headMisp,
  output robStrobe_t      strobe,
  output logic [TagW-1:0] headIdx,
  output logic [TagW-1:0] tailIdx,
  output logic            dispReady,
  output logic            commitValid,
  output logic            redirectValid
);

  localparam logic [TagW:0] PtrOne = (TagW+1)'(1);

  logic [TagW:0] headPtr;
  logic [TagW:0] tailPtr;
  logic          isFull;
  logic          commitGo;
  logic          flushGo;
  logic          allocGo;

  assign headIdx = headPtr[TagW-1:0];
  assign tailIdx = tailPtr[TagW-1:0];

  // Same slot index with opposite wrap bits means every slot is taken
  assign isFull   = (headPtr[TagW] != tailPtr[TagW]) &&
                    (headPtr[TagW-1:0] == tailPtr[TagW-1:0]);
  assign commitGo = headValid && headDone;
  assign flushGo  = commitGo && (headKind == KindBranch) && headMisp;
  assign allocGo  = dispValid && !isFull && !flushGo;

  assign dispReady     = !isFull && !flushGo;
  assign commitValid   = commitGo;
  assign redirectValid = flushGo;

  assign strobe.allocEn  = allocGo;
  assign strobe.commitEn = commitGo;
  assign strobe.flushAll = flushGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (flushGo) begin
      // The branch itself retires; everything behind it is dropped
      headPtr <= headPtr + PtrOne;
      tailPtr <= headPtr + PtrOne;
    end else begin
      if (commitGo) headPtr <= headPtr + PtrOne;
      if (allocGo)  tailPtr <= tailPtr + PtrOne;
    end
  end

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int TagW  = 4,
  parameter int DataW = 32,
  parameter int RegW  = 5,
  parameter int AddrW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  robStrobe_t       strobe,
  input  logic [TagW-1:0]  allocIdx,
  input  logic [TagW-1:0]  headIdx,
  input  instKind_e        allocKind,
  input  logic [RegW-1:0]  allocDest,
  input  logic [AddrW-1:0] allocAddr,
  input  logic             resValid,
  input  logic [TagW-1:0]  resTag,
  input  logic [DataW-1:0] resValue,
  input  logic             resMisp,
  output logic             headValid,
  output logic             headDone,
  output instKind_e        headKind,
  output logic             headMisp,
  output logic             regWrEn,
  output logic [RegW-1:0]  regWrAddr,
  output logic [DataW-1:0] regWrData,
  output logic             memWrEn,
  output logic [AddrW-1:0] memWrAddr,
  output logic [DataW-1:0] memWrData,
  output logic [DataW-1:0] redirectPc
);

  localparam int Depth = 1 << TagW;

  logic [Depth-1:0] entValid;
  logic [Depth-1:0] entDone;
  logic [Depth-1:0] entMisp;
  instKind_e        entKind  [Depth];
  logic [RegW-1:0]  entDest  [Depth];
  logic [DataW-1:0] entValue [Depth];
  logic [AddrW-1:0] entAddr  [Depth];

  for (genvar e = 0; e < Depth; e++) begin : g_ent
    logic allocHit;
    logic resHit;
    logic commitHit;

    assign allocHit  = strobe.allocEn  && (allocIdx == TagW'(e));
    assign resHit    = resValid && entValid[e] && (resTag == TagW'(e));
    assign commitHit = strobe.commitEn && (headIdx == TagW'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entDone[e]  <= 1'b0;
        entMisp[e]  <= 1'b0;
        entKind[e]  <= KindAlu;
        entDest[e]  <= '0;
        entValue[e] <= '0;
        entAddr[e]  <= '0;
      end else if (strobe.flushAll) begin
        entValid[e] <= 1'b0;
        entDone[e]  <= 1'b0;
      end else begin
        if (allocHit) begin
          entValid[e] <= 1'b1;
          entDone[e]  <= 1'b0;
          entMisp[e]  <= 1'b0;
          entKind[e]  <= allocKind;
          entDest[e]  <= allocDest;
          entAddr[e]  <= allocAddr;
        end else if (resHit) begin
          entDone[e]  <= 1'b1;
          entValue[e] <= resValue;
          entMisp[e]  <= resMisp;
        end
        if (commitHit) begin
          entValid[e] <= 1'b0;
          entDone[e]  <= 1'b0;
        end
      end
    end
  end

  assign headValid = entValid[headIdx];
  assign headDone  = entDone[headIdx];
  assign headKind  = entKind[headIdx];
  assign headMisp  = entMisp[headIdx];

  // Write ports are driven only in the retiring cycle
  assign regWrEn   = strobe.commitEn &&
                     ((headKind == KindAlu) || (headKind == KindLoad));
  assign regWrAddr = entDest[headIdx];
  assign regWrData = entValue[headIdx];
  assign memWrEn   = strobe.commitEn && (headKind == KindStore);
  assign memWrAddr = entAddr[headIdx];
  assign memWrData = entValue[headIdx];
  assign redirectPc = entValue[headIdx];

endmodule

// File: rtl/rob_commit_top.sv
module rob_commit_top
  import rob_pkg::*;
#(
  parameter int TagW  = 4,
  parameter int DataW = 32,
  parameter int RegW  = 5,
  parameter int AddrW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [1:0]       dispKind,
  input  logic [RegW-1:0]  dispDest,
  input  logic [AddrW-1:0] dispAddr,
  output logic             dispReady,
  output logic [TagW-1:0]  dispTag,
  input  logic             resValid,
  input  logic [TagW-1:0]  resTag,
  input  logic [DataW-1:0] resValue,
  input  logic             resMispredict,
  output logic             commitValid,
  output logic [TagW-1:0]  commitTag,
  output logic             regWrEn,
  output logic [RegW-1:0]  regWrAddr,
  output logic [DataW-1:0] regWrData,
  output logic             memWrEn,
  output logic [AddrW-1:0] memWrAddr,
  output logic [DataW-1:0] memWrData,
  output logic             redirectValid,
  output logic [DataW-1:0] redirectPc
);

  robStrobe_t      strobe;
  logic [TagW-1:0] headIdx;
  logic [TagW-1:0] tailIdx;
  logic            headValid;
  logic            headDone;
  instKind_e       headKind;
  logic            headMisp;

  assign dispTag   = tailIdx;
  assign commitTag = headIdx;

  rob_ctrl #(.TagW(TagW)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .dispValid    (dispValid),
    .headValid    (headValid),
    .headDone     (headDone),
    .headKind     (headKind),
    .headMisp     (headMisp),
    .strobe       (strobe),
    .headIdx      (headIdx),
    .tailIdx      (tailIdx),
    .dispReady    (dispReady),
    .commitValid  (commitValid),
    .redirectValid(redirectValid)
  );

  rob_data #(.TagW(TagW), .DataW(DataW), .RegW(RegW), .AddrW(AddrW)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .allocIdx  (tailIdx),
    .headIdx   (headIdx),
    .allocKind (instKind_e'(dispKind)),
    .allocDest (dispDest),
    .allocAddr (dispAddr),
    .resValid  (resValid),
    .resTag    (resTag),
    .resValue  (resValue),
    .resMisp   (resMispredict),
    .headValid (headValid),
    .headDone  (headDone),
    .headKind  (headKind),
    .headMisp  (headMisp),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .redirectPc(redirectPc)
  );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int TagW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            dispValid,
  input logic            dispReady,
  input logic [TagW-1:0] dispTag,
  input logic            commitValid,
  input logic [TagW-1:0] commitTag,
  input logic            regWrEn,
  input logic            memWrEn,
  input logic            redirectValid
);

  a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady) |=> (dispTag == TagW'($past(dispTag) + 1)))
    else $error("R2 tag did not advance after accepted dispatch");

  a_r3_stall_holds_tag: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady && !redirectValid) |=> $stable(dispTag))
    else $error("R3 refused dispatch moved the tail");

  a_r5_reg_write_at_commit: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (commitValid && !memWrEn))
    else $error("R5 register write outside retirement");

  a_r6_mem_write_at_commit: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> commitValid)
    else $error("R6 memory write outside retirement");

  a_r5_commit_in_order: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> (!commitValid || (commitTag == TagW'($past(commitTag) + 1))))
    else $error("R5 back-to-back retirements out of order");

  a_r8_redirect_pulse: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (!redirectValid && !commitValid && dispReady))
    else $error("R8 buffer not empty after redirect");

  a_r8_redirect_is_commit: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (commitValid && !regWrEn && !memWrEn))
    else $error("R8 redirect without branch retirement");

endmodule

bind rob_commit_top rob_checker #(.TagW(TagW)) chk_i (.*);

// File: tb/rob_commit_top_tb_top.sv
`timescale 1ns/1ps
module rob_commit_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dispValid = 1'b0;
  logic [1:0]  dispKind = 2'd0;
  logic [4:0]  dispDest = '0;
  logic [31:0] dispAddr = '0;
  logic        dispReady;
  logic [3:0]  dispTag;
  logic        resValid = 1'b0;
  logic [3:0]  resTag = '0;
  logic [31:0] resValue = '0;
  logic        resMispredict = 1'b0;
  logic        commitValid;
  logic [3:0]  commitTag;
  logic        regWrEn;
  logic [4:0]  regWrAddr;
  logic [31:0] regWrData;
  logic        memWrEn;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;
  logic        redirectValid;
  logic [31:0] redirectPc;

  always #4 clk = ~clk;

  rob_commit_top dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard model, indexed by tag
  bit          expValid [16];
  bit          expDone  [16];
  bit          expMisp  [16];
  logic [1:0]  expKind  [16];
  logic [4:0]  expDest  [16];
  logic [31:0] expAddr  [16];
  logic [31:0] expValue [16];
  logic [3:0]  expTail = '0;
  logic [3:0]  orderQ [$];

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    dispValid = 1'b0;
    resValid = 1'b0;
    resMispredict = 1'b0;
  endtask

  task automatic putDisp(input logic [1:0] kind, input logic [4:0] dest,
                         input logic [31:0] addr, output logic [3:0] tag);
    bit expReady;
    expReady = (orderQ.size() < 16);
    check(dispReady == expReady, "R3", "dispReady", 32'(dispReady), 32'(expReady));
    dispValid = 1'b1;
    dispKind = kind;
    dispDest = dest;
    dispAddr = addr;
    tag = dispTag;
    if (expReady) begin
      check(dispTag == expTail, "R2", "dispTag", 32'(dispTag), 32'(expTail));
      expValid[expTail] = 1;
      expDone[expTail]  = 0;
      expMisp[expTail]  = 0;
      expKind[expTail]  = kind;
      expDest[expTail]  = dest;
      expAddr[expTail]  = addr;
      orderQ.push_back(expTail);
      tag = expTail;
      expTail = expTail + 4'd1;
    end
  endtask

  task automatic putRes(input logic [3:0] tag, input logic [31:0] val, input bit misp);
    resValid = 1'b1;
    resTag = tag;
    resValue = val;
    resMispredict = misp;
    if (expValid[tag]) begin
      expDone[tag]  = 1;
      expValue[tag] = val;
      expMisp[tag]  = misp;
    end
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (orderQ.size() != 0 && n < 200) begin
      tick();
      n++;
    end
    tick();
    check(orderQ.size() == 0, req, "pending retirements after drain", 32'(orderQ.size()), 32'd0);
    check(!commitValid, req, "commitValid when empty", 32'(commitValid), 32'd0);
  endtask

  // Monitor: every retirement must match the oldest scoreboard entry
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (commitValid) begin
        if (orderQ.size() == 0) begin
          check(0, "R8", "retirement with nothing pending, tag", 32'(commitTag), 32'hx);
        end else begin
          logic [3:0] t;
          bit eReg, eMem, eRed, ok;
          string req;
          t = orderQ.pop_front();
          eReg = (expKind[t] == 2'd0) || (expKind[t] == 2'd1);
          eMem = (expKind[t] == 2'd2);
          eRed = (expKind[t] == 2'd3) && expMisp[t];
          req = eReg ? "R5" : (eMem ? "R6" : (eRed ? "R8" : "R7"));
          ok = (commitTag == t) && (regWrEn == eReg) && (memWrEn == eMem) &&
               (redirectValid == eRed);
          if (eReg) ok = ok && (regWrAddr == expDest[t]) && (regWrData == expValue[t]);
          if (eMem) ok = ok && (memWrAddr == expAddr[t]) && (memWrData == expValue[t]);
          if (eRed) ok = ok && (redirectPc == expValue[t]);
          check(ok, req, $sformatf("retire tag %0d reg=%b mem=%b redir=%b", t, regWrEn, memWrEn,
                redirectValid), {28'd0, commitTag}, {28'd0, t});
          check(expDone[t], "R4", "retired without result, tag", 32'(t), 32'(t));
          expValid[t] = 0;
          if (eRed) begin
            foreach (orderQ[i]) expValid[orderQ[i]] = 0;
            orderQ.delete();
            expTail = t + 4'd1;
          end
        end
      end else if (regWrEn || memWrEn || redirectValid) begin
        check(0, "R6", "write strobe without retirement", {29'd0, regWrEn, memWrEn, redirectValid}, 32'd0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] tg [16];
    logic [3:0] t0, tb, ty;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check(dispReady == 1'b1, "R1", "dispReady", 32'(dispReady), 32'd1);
    check(dispTag == 4'd0, "R1", "dispTag", 32'(dispTag), 32'd0);
    check({commitValid, regWrEn, memWrEn, redirectValid} == 4'd0, "R1", "strobes",
          32'({commitValid, regWrEn, memWrEn, redirectValid}), 32'd0);

    // R4: out-of-order completion, head blocks retirement
    for (int i = 0; i < 4; i++) begin
      putDisp(2'd0, 5'(i + 1), 32'd0, tg[i]);
      tick();
    end
    putRes(tg[3], 32'h0000_0033, 0); tick();
    putRes(tg[1], 32'h0000_0011, 0); tick();
    putRes(tg[2], 32'h0000_0022, 0); tick();
    repeat (3) tick();
    check(!commitValid, "R4", "retired while head lacks result", 32'(commitValid), 32'd0);
    putRes(tg[0], 32'h0000_0010, 0); tick();
    drain("R5");

    // R6 store, R5 load, R7 correctly predicted branch
    putDisp(2'd2, 5'd0, 32'h0000_0100, tg[0]); tick();
    putDisp(2'd1, 5'd9, 32'd0, tg[1]); tick();
    putDisp(2'd3, 5'd0, 32'd0, tg[2]); tick();
    putRes(tg[2], 32'h0000_8000, 0); tick();
    putRes(tg[1], 32'h0000_0055, 0); tick();
    check(!memWrEn, "R6", "store reached memory before result", 32'(memWrEn), 32'd0);
    putRes(tg[0], 32'h0000_CAFE, 0); tick();
    drain("R7");

    // Dispatch and retirement in the same cycle
    putDisp(2'd0, 5'd3, 32'd0, t0); tick();
    for (int i = 0; i < 8; i++) begin
      logic [3:0] nt;
      putRes(t0, 32'h100 + 32'(i), 0);
      putDisp(2'd0, 5'(i + 4), 32'd0, nt);
      tick();
      t0 = nt;
    end
    putRes(t0, 32'h0000_0200, 0); tick();
    drain("R2");

    // R3 full buffer, tags wrap
    for (int i = 0; i < 16; i++) begin
      putDisp(2'(i % 3), 5'(i), 32'h0000_1000 + 32'(i * 4), tg[i]);
      tick();
    end
    t0 = dispTag;
    putDisp(2'd0, 5'd1, 32'd0, ty); tick();
    check(dispTag == t0, "R3", "dispTag after refused dispatch", 32'(dispTag), 32'(t0));
    for (int i = 15; i >= 0; i--) begin
      putRes(tg[i], 32'hA000_0000 + 32'(i), 0);
      tick();
    end
    drain("R3");

    // R9 result to an invalid tag
    t0 = expTail;
    putRes(t0, 32'hDEAD_0000, 0); tick();
    putDisp(2'd0, 5'd7, 32'd0, ty); tick();
    check(ty == t0, "R9", "reused tag", 32'(ty), 32'(t0));
    repeat (4) tick();
    check(!commitValid, "R9", "slot retired from stale result", 32'(commitValid), 32'd0);
    putRes(ty, 32'h0000_0077, 0); tick();
    drain("R9");

    // R8 mispredicted branch flush
    putDisp(2'd3, 5'd0, 32'd0, tb); tick();
    putDisp(2'd0, 5'd1, 32'd0, tg[0]); tick();
    putDisp(2'd2, 5'd0, 32'h0000_0300, tg[1]); tick();
    putDisp(2'd0, 5'd3, 32'd0, tg[2]); tick();
    putRes(tg[0], 32'h0000_0001, 0); tick();
    putRes(tg[1], 32'h0000_0002, 0); tick();
    putRes(tb, 32'h0000_4A00, 1); tick();
    check(redirectValid && redirectPc == 32'h0000_4A00, "R8", "redirect target",
          redirectPc, 32'h0000_4A00);
    tick();
    check(dispReady && !commitValid && !redirectValid, "R8", "empty after flush",
          32'({dispReady, commitValid, redirectValid}), 32'b100);
    check(dispTag == tb + 4'd1, "R8", "tail after flush", 32'(dispTag), 32'(tb + 4'd1));
    putRes(tg[2], 32'h0000_0003, 0); tick();
    putDisp(2'd0, 5'd4, 32'd0, ty); tick();
    check(ty == tb + 4'd1, "R8", "tag after flush", 32'(ty), 32'(tb + 4'd1));
    repeat (4) tick();
    check(!commitValid, "R8", "cancelled result reached new slot", 32'(commitValid), 32'd0);
    putRes(ty, 32'h0000_0044, 0); tick();
    drain("R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule